// File: doc/BRIEF.md
# Target IU Exception Phase Sequencer

This block sits on the target side of a packetized parallel SCSI link while the target receives information units (IUs) in the DT DATA OUT phase. At the end of each received IU it decides which bus phase the target should request next. The choices are to keep receiving, to go to MSG OUT, to switch to DT DATA IN to return a status pair, or to release the bus with an unexpected bus free. The decision depends on three things: whether the attention line was seen during that IU, whether the IU failed its CRC, and whether an I_T_L_Q nexus has already been identified.

Bus phase logic drives the block with a one-cycle pulse at the start and at the end of each IU. With the end pulse it gives the IU kind and the CRC verdict. Once the decision has been carried out, it sends back completion pulses for the message phase, the status pair and the bus free. The block holds a nexus-valid flag and an error-pending flag. It asks for a status reply carrying CHECK CONDITION when a CRC error has to be reported. It also asks for a status reply when attention broke an L_Q/Command pair before the Command IU could arrive, because that Command IU can never be received afterwards.

Top module: `iu_phase_sequencer`

## Requirements
- R1: Attention seen at any cycle from an IU's start pulse up to and including its end pulse makes the block request MSG OUT (`next_phase` = 01). The request comes in the cycle after the end pulse and never while the IU is still in progress.
- R2: A CRC error on an L_Q IU (`iu_kind` = 0) requests bus free (`next_phase` = 11) even if attention was also seen. A CRC error on any IU while no nexus is valid does the same. In both cases the nexus-valid and error-pending flags are cleared.
- R3: With a valid nexus, a CRC error on a Command/Data IU (`iu_kind` = 1) without attention requests status (`next_phase` = 10) with `check_cond` = 1 and sets `err_pending`.
- R4: With a valid nexus, a CRC error together with attention first requests MSG OUT. The status request with `check_cond` = 1 follows in the cycle after the `msg_done` pulse.
- R5: Attention on an L_Q IU without a CRC error sets the nexus and requests MSG OUT. After `msg_done` the block requests status with `check_cond` = 0 and does not wait for the Command IU.
- R6: An IU with no CRC error and no attention requests continue (`next_phase` = 00). An L_Q IU without a CRC error sets `nexus_valid`.
- R7: `nexus_valid` stays set through the MSG OUT wait and through the status reply. Only a bus free decision or reset clears it.
- R8: While the block waits for `msg_done`, `status_done` or `free_done`, an IU end pulse produces no decision.
- R9: `err_pending` stays set until the `status_done` pulse and is cleared by it.
- R10: After reset, `next_valid`, `check_cond`, `nexus_valid` and `err_pending` are 0 and `next_phase` is 00. A `free_done` pulse after bus free lets the block accept IUs again.
- R11: Attention asserted and removed between IUs, outside any start-to-end window, has no effect on the next IU's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iu_start | input | 1 | Pulse: first cycle of an IU |
| iu_end | input | 1 | Pulse: last cycle of an IU; kind and CRC verdict are valid with it |
| iu_kind | input | 1 | 0 = L_Q IU, 1 = Command or Data IU |
| crc_err | input | 1 | CRC verdict of the ending IU (1 = error) |
| atn | input | 1 | Attention line level |
| msg_done | input | 1 | Pulse: the MSG OUT phase has completed |
| status_done | input | 1 | Pulse: the L_Q/Status pair has been sent |
| free_done | input | 1 | Pulse: the bus has reached bus free |
| next_valid | output | 1 | One-cycle pulse marking a new phase decision |
| next_phase | output | 2 | 00 continue, 01 MSG OUT, 10 DT DATA IN status, 11 bus free |
| check_cond | output | 1 | With a status decision: report CHECK CONDITION |
| nexus_valid | output | 1 | An I_T_L_Q nexus is established |
| err_pending | output | 1 | A CRC error awaits its status reply |

## Verification
The embedded assertions check on every cycle that MSG OUT requests come only right after an IU end pulse. They also check that an L_Q CRC error always yields bus free, that CHECK CONDITION is flagged only with a status decision, that the nexus survives the message phase, that no decision appears while a phase completion is awaited, and that the error flag holds until its status is sent. The bench scenarios are needed to show the ordered sequences: MSG OUT followed by a status request with or without CHECK CONDITION, which of attention and a CRC error wins, attention outside an IU being ignored, and IUs ignored while waiting.

// File: rtl/iu_seq_pkg.sv
// Shared encodings for the IU exception phase sequencer.
// Assumes the phase code values are decoded by the bus phase logic as is.
package iu_seq_pkg;
    typedef enum logic [1:0] {
        PH_CONT    = 2'd0,
        PH_MSGOUT  = 2'd1,
        PH_STATUS  = 2'd2,
        PH_BUSFREE = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ST_XFER,
        ST_MSG,
        ST_STAT,
        ST_FREE
    } seq_state_e;

    localparam logic KIND_LQ  = 1'b0;
    localparam logic KIND_CMD = 1'b1;
endpackage

// File: rtl/iu_atn_tracker.sv
// Attention tracker: records whether attention was seen inside the window
// of the current IU (start pulse through end pulse) and reports it with the
// end pulse. Assumes start and end pulses are one cycle wide.
module iu_atn_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic iu_start,
    input  logic iu_end,
    input  logic atn,
    output logic atn_at_end
);
    logic in_iu;
    logic atn_seen;

    // Marks the cycles between an IU start pulse and its end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        in_iu <= 1'b0;
        else if (iu_end)   in_iu <= 1'b0;
        else if (iu_start) in_iu <= 1'b1;
    end

    // Latches attention seen inside the IU window; clears at the IU end.
    always_ff @(posedge clk) begin
        if (!rst_n)                          atn_seen <= 1'b0;
        else if (iu_end)                     atn_seen <= 1'b0;
        else if ((in_iu || iu_start) && atn) atn_seen <= 1'b1;
    end

    assign atn_at_end = iu_end && (atn_seen || atn);

    AST_ATN_ONLY_IN_IU: assert property (@(posedge clk) disable iff (!rst_n)
        atn_seen |-> in_iu); // R11
endmodule

// File: rtl/iu_context_regs.sv
// Context registers: the nexus-valid flag, the CRC error-pending flag and
// the flag that a status reply is owed for a broken L_Q/Command pair.
// Assumes kill (bus free) and set requests never coincide for one flag.
module iu_context_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic nexus_set,
    input  logic kill,
    input  logic err_set,
    input  logic owe_set,
    input  logic flags_clr,
    output logic nexus_valid,
    output logic err_pending,
    output logic owe_status
);
    // Nexus flag: set by a clean L_Q, dropped by bus free.
    always_ff @(posedge clk) begin
        if (!rst_n)         nexus_valid <= 1'b0;
        else if (kill)      nexus_valid <= 1'b0;
        else if (nexus_set) nexus_valid <= 1'b1;
    end

    // Error-pending flag: held until its status pair is sent or bus free.
    always_ff @(posedge clk) begin
        if (!rst_n)                 err_pending <= 1'b0;
        else if (kill || flags_clr) err_pending <= 1'b0;
        else if (err_set)           err_pending <= 1'b1;
    end

    // Owed-status flag for a pair interrupted by attention after the L_Q.
    always_ff @(posedge clk) begin
        if (!rst_n)                 owe_status <= 1'b0;
        else if (kill || flags_clr) owe_status <= 1'b0;
        else if (owe_set)           owe_status <= 1'b1;
    end

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pending && !flags_clr && !kill) |=> err_pending); // R9

    AST_NEXUS_DROP_ON_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !nexus_valid && !err_pending); // R2
endmodule

// File: rtl/iu_phase_fsm.sv
// Decision state machine: at each IU end it resolves CRC errors and
// attention against the nexus state and issues one registered phase
// decision, then waits for the matching completion pulse.
// Assumes completion pulses only arrive for the phase that was requested.
module iu_phase_fsm
    import iu_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   iu_end,
    input  logic   iu_kind,
    input  logic   crc_err,
    input  logic   atn_at_end,
    input  logic   msg_done,
    input  logic   status_done,
    input  logic   free_done,
    input  logic   nexus_valid,
    input  logic   err_pending,
    input  logic   owe_status,
    output logic   dec_valid,
    output phase_e dec_phase,
    output logic   dec_chk,
    output logic   nexus_set,
    output logic   kill,
    output logic   err_set,
    output logic   owe_set,
    output logic   flags_clr
);
    seq_state_e state, state_nxt;
    logic       v_nxt;
    phase_e     ph_nxt;
    logic       chk_nxt;

    // Next-state and decision logic for the current state and strobes.
    always_comb begin
        state_nxt = state;
        v_nxt     = 1'b0;
        ph_nxt    = PH_CONT;
        chk_nxt   = 1'b0;
        nexus_set = 1'b0;
        kill      = 1'b0;
        err_set   = 1'b0;
        owe_set   = 1'b0;
        flags_clr = 1'b0;
        case (state)
            ST_XFER: begin
                if (iu_end) begin
                    v_nxt = 1'b1;
                    if (crc_err && (iu_kind == KIND_LQ || !nexus_valid)) begin
                        ph_nxt    = PH_BUSFREE;
                        kill      = 1'b1;
                        state_nxt = ST_FREE;
                    end else if (crc_err) begin
                        err_set = 1'b1;
                        if (atn_at_end) begin
                            ph_nxt    = PH_MSGOUT;
                            state_nxt = ST_MSG;
                        end else begin
                            ph_nxt    = PH_STATUS;
                            chk_nxt   = 1'b1;
                            state_nxt = ST_STAT;
                        end
                    end else begin
                        if (iu_kind == KIND_LQ) nexus_set = 1'b1;
                        if (atn_at_end) begin
                            ph_nxt    = PH_MSGOUT;
                            state_nxt = ST_MSG;
                            if (iu_kind == KIND_LQ) owe_set = 1'b1;
                        end
                    end
                end
            end
            ST_MSG: begin
                if (msg_done) begin
                    v_nxt = 1'b1;
                    if (err_pending || owe_status) begin
                        ph_nxt    = PH_STATUS;
                        chk_nxt   = err_pending;
                        state_nxt = ST_STAT;
                    end else begin
                        state_nxt = ST_XFER;
                    end
                end
            end
            ST_STAT: begin
                if (status_done) begin
                    flags_clr = 1'b1;
                    state_nxt = ST_XFER;
                end
            end
            default: begin
                if (free_done) state_nxt = ST_XFER;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_XFER;
        else        state <= state_nxt;
    end

    // Registered decision outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_phase <= PH_CONT;
            dec_chk   <= 1'b0;
        end else begin
            dec_valid <= v_nxt;
            dec_phase <= ph_nxt;
            dec_chk   <= chk_nxt;
        end
    end

    AST_MSGOUT_AT_IU_END: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_phase == PH_MSGOUT) |-> $past(iu_end)); // R1

    AST_LQ_CRC_BUSFREE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && iu_end && iu_kind == KIND_LQ && crc_err)
        |=> (dec_valid && dec_phase == PH_BUSFREE)); // R2

    AST_CHK_ONLY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_chk) |-> dec_phase == PH_STATUS); // R3

    AST_NEXUS_KEPT_IN_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MSG && nexus_valid) |=> nexus_valid); // R7

    AST_QUIET_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STAT || state == ST_FREE) |=> !dec_valid); // R8
endmodule

// File: rtl/iu_phase_sequencer.sv
// Top of the IU exception phase sequencer. Connects the attention tracker,
// the context registers and the decision state machine.
// Assumes all inputs are synchronous to clk.
module iu_phase_sequencer
    import iu_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       iu_start,
    input  logic       iu_end,
    input  logic       iu_kind,
    input  logic       crc_err,
    input  logic       atn,
    input  logic       msg_done,
    input  logic       status_done,
    input  logic       free_done,
    output logic       next_valid,
    output logic [1:0] next_phase,
    output logic       check_cond,
    output logic       nexus_valid,
    output logic       err_pending
);
    logic   atn_at_end;
    logic   owe_status;
    logic   nexus_set, kill, err_set, owe_set, flags_clr;
    phase_e dec_phase;

    iu_atn_tracker u_atn (
        .clk        (clk),
        .rst_n      (rst_n),
        .iu_start   (iu_start),
        .iu_end     (iu_end),
        .atn        (atn),
        .atn_at_end (atn_at_end)
    );

    iu_context_regs u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .nexus_set   (nexus_set),
        .kill        (kill),
        .err_set     (err_set),
        .owe_set     (owe_set),
        .flags_clr   (flags_clr),
        .nexus_valid (nexus_valid),
        .err_pending (err_pending),
        .owe_status  (owe_status)
    );

    iu_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .iu_end      (iu_end),
        .iu_kind     (iu_kind),
        .crc_err     (crc_err),
        .atn_at_end  (atn_at_end),
        .msg_done    (msg_done),
        .status_done (status_done),
        .free_done   (free_done),
        .nexus_valid (nexus_valid),
        .err_pending (err_pending),
        .owe_status  (owe_status),
        .dec_valid   (next_valid),
        .dec_phase   (dec_phase),
        .dec_chk     (check_cond),
        .nexus_set   (nexus_set),
        .kill        (kill),
        .err_set     (err_set),
        .owe_set     (owe_set),
        .flags_clr   (flags_clr)
    );

    assign next_phase = dec_phase;
endmodule

// File: tb/tb_iu_phase_sequencer.sv
module tb_iu_phase_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iu_start = 1'b0, iu_end = 1'b0, iu_kind = 1'b0, crc_err = 1'b0;
    logic       atn = 1'b0, msg_done = 1'b0, status_done = 1'b0, free_done = 1'b0;
    logic       next_valid, check_cond, nexus_valid, err_pending;
    logic [1:0] next_phase;

    int compared = 0;
    int mismatched = 0;
    bit reported = 1'b0;

    logic [1:0] q_ph[$];
    logic       q_chk[$];
    string      q_tag[$];

    always #2 clk = ~clk;

    iu_phase_sequencer dut (
        .clk(clk), .rst_n(rst_n), .iu_start(iu_start), .iu_end(iu_end),
        .iu_kind(iu_kind), .crc_err(crc_err), .atn(atn), .msg_done(msg_done),
        .status_done(status_done), .free_done(free_done),
        .next_valid(next_valid), .next_phase(next_phase),
        .check_cond(check_cond), .nexus_valid(nexus_valid),
        .err_pending(err_pending)
    );

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_dec(input logic [1:0] ph, input logic chk, input string tag);
        q_ph.push_back(ph);
        q_chk.push_back(chk);
        q_tag.push_back(tag);
    endtask

    // Monitor: pops expected decisions as the design produces them.
    always @(negedge clk) begin
        if (rst_n && next_valid) begin
            if (q_ph.size() == 0) begin
                compared++;
                mismatched++;
                $display("FAIL R8: unexpected decision actual %0d expected none", next_phase);
            end else begin
                logic [1:0] eph;
                logic       echk;
                string      etag;
                eph = q_ph.pop_front();
                echk = q_chk.pop_front();
                etag = q_tag.pop_front();
                check({etag, " phase"}, int'(next_phase), int'(eph));
                check({etag, " check_cond"}, int'(check_cond), int'(echk));
            end
        end
    end

    // atn_mode: 0 none, 1 mid-IU only, 2 only with the end pulse
    task automatic run_iu(input logic kind, input logic crc, input int atn_mode);
        @(negedge clk); iu_start = 1'b1; iu_kind = kind;
        @(negedge clk); iu_start = 1'b0; atn = (atn_mode == 1);
        @(negedge clk); atn = 1'b0;
        @(negedge clk); iu_end = 1'b1; crc_err = crc; atn = (atn_mode == 2);
        @(negedge clk); iu_end = 1'b0; crc_err = 1'b0; atn = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) msg_done = 1'b1;
        else if (which == 1) status_done = 1'b1;
        else free_done = 1'b1;
        @(negedge clk);
        msg_done = 1'b0; status_done = 1'b0; free_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 next_valid", int'(next_valid), 0);
        check("R10 next_phase", int'(next_phase), 0);
        check("R10 check_cond", int'(check_cond), 0);
        check("R10 nexus_valid", int'(nexus_valid), 0);
        check("R10 err_pending", int'(err_pending), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 clean L_Q then clean Command IU
        expect_dec(2'd0, 1'b0, "R6 clean LQ");
        run_iu(1'b0, 1'b0, 0);
        check("R6 nexus set", int'(nexus_valid), 1);
        expect_dec(2'd0, 1'b0, "R6 clean cmd");
        run_iu(1'b1, 1'b0, 0);

        // R1 attention mid-IU on a data IU
        expect_dec(2'd1, 1'b0, "R1 atn mid IU");
        run_iu(1'b1, 1'b0, 1);
        check("R7 nexus in msg", int'(nexus_valid), 1);
        expect_dec(2'd0, 1'b0, "R1 resume after msg");
        pulse(0);

        // R11 attention between IUs
        @(negedge clk); atn = 1'b1;
        repeat (2) @(negedge clk);
        atn = 1'b0;
        expect_dec(2'd0, 1'b0, "R11 atn outside IU");
        run_iu(1'b1, 1'b0, 0);

        // R3 CRC on command with nexus, no attention
        expect_dec(2'd2, 1'b1, "R3 crc status");
        run_iu(1'b1, 1'b1, 0);
        check("R3 err_pending", int'(err_pending), 1);
        // R8 IU ignored while awaiting status
        run_iu(1'b0, 1'b1, 0);
        check("R9 err held", int'(err_pending), 1);
        pulse(1);
        check("R9 err cleared", int'(err_pending), 0);
        check("R7 nexus after status", int'(nexus_valid), 1);

        // R4 attention and CRC together with nexus
        expect_dec(2'd1, 1'b1 ^ 1'b1, "R4 msg first");
        run_iu(1'b1, 1'b1, 1);
        check("R4 err_pending", int'(err_pending), 1);
        expect_dec(2'd2, 1'b1, "R4 status after msg");
        pulse(0);
        pulse(1);

        // R5 attention on clean L_Q breaks the pair
        expect_dec(2'd1, 1'b0, "R5 msg after LQ");
        run_iu(1'b0, 1'b0, 2);
        check("R5 nexus set", int'(nexus_valid), 1);
        expect_dec(2'd2, 1'b0, "R5 status no chk");
        pulse(0);
        pulse(1);

        // R2 attention plus L_Q CRC error: bus free wins
        expect_dec(2'd3, 1'b0, "R2 lq crc busfree");
        run_iu(1'b0, 1'b1, 1);
        check("R2 nexus cleared", int'(nexus_valid), 0);
        check("R2 err cleared", int'(err_pending), 0);
        run_iu(1'b1, 1'b0, 0); // R8 ignored while awaiting bus free
        pulse(2);

        // R2 CRC on command with no nexus
        expect_dec(2'd3, 1'b0, "R2 no nexus busfree");
        run_iu(1'b1, 1'b1, 0);
        pulse(2);
        // R10 accepting again after free_done
        expect_dec(2'd0, 1'b0, "R10 after free");
        run_iu(1'b0, 1'b0, 0);

        repeat (4) @(negedge clk);
        check("R8 queue drained", q_ph.size(), 0);
        finish_run();
    end
endmodule